// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Optional Ninth Bit

This block turns a byte written by a host into an asynchronous serial frame on a single line. Two frame lengths are selectable at write time. The short frame has a zero start bit, eight data bits sent least significant bit first, and a one stop bit. The long frame inserts a ninth, host-chosen bit between the last data bit and the stop bit, which can carry parity or an address/data marker.

Bit timing comes from an external tick that pulses at sixteen times the baud rate. Inside, a divide-by-sixteen counter runs freely on that tick. Every bit edge of a frame falls on one of its rollovers. A write therefore does not start the frame at once. The start bit begins at the first rollover that follows the write.

The shift register is loaded with the data byte and an end marker. Zeros fill it from the top as it shifts. The frame is over when only the marker and the current output bit are still non-zero. A sticky done flag then rises and stays up until the host clears it.

Top module: `async_tx9`

## Requirements
- R1: After reset the line `txd` is 1, `tx_done` is 0 and the tick counter is at 0. The line stays at 1 whenever no frame is being sent.
- R2: A write accepted while idle leaves the line at 1 until the first counter rollover in a later cycle. A rollover is a `tick16` pulse while the counter is at 15. A rollover in the same cycle as the write does not count.
- R3: The start bit is 0 and lasts from the first to the second rollover after the write. Data bit i (0 = least significant) is driven from rollover 2+i to rollover 3+i.
- R4: In the short frame (`frame11` = 0 at write), `tx_done` rises at the 10th rollover after the write. From that rollover the line is 1.
- R5: In the long frame (`frame11` = 1 at write), the ninth bit (`ninth_bit` at write) is driven from rollover 10 to rollover 11. `tx_done` rises at the 11th rollover and the line is 1 from then on. This holds even for data whose upper bits are all zero.
- R6: Once set, `tx_done` stays 1 until a cycle with `clr_done` = 1 clears it from the next cycle on. When completion and `clr_done` fall in the same cycle, completion wins.
- R7: A write is ignored from the write cycle until the rollover that ends the frame, that rollover's own cycle included. Ignored writes change neither the frame being sent nor anything afterwards.
- R8: `wr_data`, `frame11` and `ninth_bit` are captured in the write cycle. Later changes to them have no effect on that frame.
- R9: The counter advances only on `tick16`. Without ticks no rollover occurs, so a pending frame does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the baud rate |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| frame11 | input | 1 | 1 selects the long frame with a ninth bit |
| ninth_bit | input | 1 | Ninth bit value for the long frame |
| clr_done | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idles high |
| tx_done | output | 1 | Sticky frame-complete flag |

## Verification
Every result here is due a fixed number of counter rollovers after the write, not a fixed number of clocks. Each line level and the done flag change in the cycle right after the rising edge that saw the rollover. The bench keeps its own tick counter and an ordered queue of expected line levels. On each rollover edge it pops the queue, raises done once the queue is empty, and compares both outputs with the model half a clock after every edge. The directed cases place writes exactly on a rollover cycle and on the done cycle, run the tick at several rates, and stop the tick altogether.

// File: rtl/async_tx9_pkg.sv
package async_tx9_pkg;

    localparam int TX_DATA_W = 8;
    localparam int TX_SR_W   = TX_DATA_W + 1;

    typedef logic [TX_SR_W-1:0] tx_shreg_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_WAIT  = 2'd1,
        TX_START = 2'd2,
        TX_DATA  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic [TX_DATA_W-1:0] data;
        logic                 ninth;
        logic                 wide;
    } tx_req_t;

    // Bit placed above the data byte at load: the frame's ninth bit or a stop marker.
    function automatic logic top_bit(input tx_req_t r);
        return r.wide ? r.ninth : 1'b1;
    endfunction

    // Only the marker (one position up) and the output bit may still be non-zero.
    function automatic logic marker_reached(input tx_shreg_t s);
        return (s[TX_SR_W-1:2] == '0) && s[1];
    endfunction

endpackage

// File: rtl/async_tx9_tick_div.sv
module async_tx9_tick_div #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic roll
);
    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign roll = tick && (cnt_q == LAST);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/async_tx9_shifter.sv
module async_tx9_shifter
    import async_tx9_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  tx_req_t req,
    input  logic    shift_en,
    output logic    out_bit,
    output logic    last_due
);
    tx_shreg_t sr_q;
    logic      wide_q;
    logic      first_q;
    logic      fill;

    // The first shift of a long frame brings in the stop marker; zeros follow.
    assign fill = wide_q && first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q    <= '1;
            wide_q  <= 1'b0;
            first_q <= 1'b0;
        end else if (load) begin
            sr_q    <= {top_bit(req), req.data};
            wide_q  <= req.wide;
            first_q <= 1'b1;
        end else if (shift_en) begin
            sr_q    <= {fill, sr_q[TX_SR_W-1:1]};
            first_q <= 1'b0;
        end
    end

    assign out_bit  = sr_q[0];
    assign last_due = !first_q && marker_reached(sr_q);

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift_en) |=> $stable(sr_q)); // R7

endmodule

// File: rtl/async_tx9_ctrl.sv
module async_tx9_ctrl
    import async_tx9_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_stb,
    input  logic      roll,
    input  logic      last_due,
    input  logic      clr_done,
    output logic      load,
    output logic      shift_en,
    output tx_state_e state,
    output logic      tx_done
);
    tx_state_e state_q, state_d;
    logic      done_q;
    logic      finish;

    assign load     = wr_stb && (state_q == TX_IDLE);
    assign shift_en = (state_q == TX_DATA) && roll;
    assign finish   = shift_en && last_due;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_WAIT;
            TX_WAIT:  if (roll) state_d = TX_START;
            TX_START: if (roll) state_d = TX_DATA;
            TX_DATA:  if (finish) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (finish) begin
                done_q <= 1'b1;
            end else if (clr_done) begin
                done_q <= 1'b0;
            end
        end
    end

    assign state   = state_q;
    assign tx_done = done_q;

    AST_START_ON_ROLL: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == TX_START) |-> $past(roll)); // R2
    AST_DONE_ON_ROLL: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(roll)); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done_q && !clr_done) |=> done_q); // R6
    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (finish && clr_done) |=> done_q); // R6

endmodule

// File: rtl/async_tx9.sv
module async_tx9
    import async_tx9_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick16,
    input  logic                 wr_stb,
    input  logic [TX_DATA_W-1:0] wr_data,
    input  logic                 frame11,
    input  logic                 ninth_bit,
    input  logic                 clr_done,
    output logic                 txd,
    output logic                 tx_done
);
    logic      roll;
    logic      load;
    logic      shift_en;
    logic      out_bit;
    logic      last_due;
    tx_state_e state;
    tx_req_t   req;

    assign req = '{data: wr_data, ninth: ninth_bit, wide: frame11};

    async_tx9_tick_div #(.OVERSAMPLE(OVERSAMPLE)) div_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick16),
        .roll (roll)
    );

    async_tx9_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .roll     (roll),
        .last_due (last_due),
        .clr_done (clr_done),
        .load     (load),
        .shift_en (shift_en),
        .state    (state),
        .tx_done  (tx_done)
    );

    async_tx9_shifter shf_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .req      (req),
        .shift_en (shift_en),
        .out_bit  (out_bit),
        .last_due (last_due)
    );

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = out_bit;
            default:  txd = 1'b1;
        endcase
    end

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((state == TX_IDLE) || (state == TX_WAIT)) |-> txd); // R1

endmodule

// File: tb/async_tx9_tb_top.sv
module async_tx9_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       frame11 = 1'b0;
    logic       ninth_bit = 1'b0;
    logic       clr_done = 1'b0;
    logic       txd;
    logic       tx_done;

    always #2.5 clk = ~clk;

    async_tx9 dut_i (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_stb(wr_stb),
        .wr_data(wr_data), .frame11(frame11), .ninth_bit(ninth_bit),
        .clr_done(clr_done), .txd(txd), .tx_done(tx_done)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    int    tick_per = 1;
    int    tick_cnt = 0;
    int    cycles   = 0;
    bit    finished = 0;

    // Reference model state
    int   m_cnt  = 0;
    bit   m_pend = 0;
    bit   m_act  = 0;
    bit   m_line = 1;
    bit   m_done = 0;
    bit   m_q[$];

    task automatic check(input string req, input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %b expected %b at cycle %0d", req, what, got, exp, cycles);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Tick generator
    always @(negedge clk) begin
        if (tick_per == 0) begin
            tick16 <= 1'b0;
        end else begin
            tick16 <= (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1 >= tick_per) ? 0 : tick_cnt + 1;
        end
    end

    // Behavioural reference model
    always @(posedge clk) begin
        bit roll, accept, set_done;
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_act = 0; m_line = 1; m_done = 0;
            m_q.delete();
        end else begin
            roll     = tick16 && (m_cnt == 15);
            accept   = wr_stb && !m_pend && !m_act;
            set_done = 0;
            if (roll && m_pend) begin
                m_pend = 0; m_act = 1;
                m_line = m_q.pop_front();
            end else if (roll && m_act) begin
                if (m_q.size() != 0) begin
                    m_line = m_q.pop_front();
                end else begin
                    m_line = 1; m_act = 0; set_done = 1;
                end
            end
            if (accept) begin
                m_pend = 1;
                m_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_q.push_back(wr_data[i]);
                if (frame11) m_q.push_back(ninth_bit);
            end
            if (set_done) m_done = 1;
            else if (clr_done) m_done = 0;
            if (tick16) m_cnt = (m_cnt + 1) % 16;
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (!rst && !finished) begin
            check(cur_req, txd, m_line, "txd vs model");
            check(cur_req, tx_done, m_done, "tx_done vs model");
        end
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            summary();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input logic [7:0] d, input logic wide, input logic nb);
        @(negedge clk);
        wr_stb = 1; wr_data = d; frame11 = wide; ninth_bit = nb;
        @(negedge clk);
        wr_stb = 0; wr_data = ~d; frame11 = ~wide; ninth_bit = ~nb; // R8: later changes ignored
    endtask

    task automatic wait_done;
        int guard = 0;
        while (tx_done !== 1'b1 && guard < 20000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic clear;
        @(negedge clk); clr_done = 1;
        @(negedge clk); clr_done = 0;
    endtask

    initial begin
        idle(4);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", txd, 1'b1, "txd after reset");
        check("R1", tx_done, 1'b0, "tx_done after reset");
        idle(5);

        // R3 R4: short frame, tick every cycle
        cur_req = "R4";
        write(8'hA5, 1'b0, 1'b0);
        check("R2", txd, 1'b1, "line high right after write");
        wait_done();
        check("R4", tx_done, 1'b1, "done after short frame");
        check("R4", txd, 1'b1, "stop level after short frame");
        // R6: sticky
        cur_req = "R6";
        idle(30);
        check("R6", tx_done, 1'b1, "done still set");
        clear();
        check("R6", tx_done, 1'b0, "done cleared");

        // R5: long frame, upper data zero, ninth bit 0, slow tick
        cur_req = "R5";
        tick_per = 3;
        write(8'h02, 1'b1, 1'b0);
        wait_done();
        check("R5", tx_done, 1'b1, "done after long frame 0x02");
        clear();

        // R8 R7: long frame ninth=1, inputs change after write, extra write mid-frame
        cur_req = "R7";
        tick_per = 2;
        write(8'hFF, 1'b1, 1'b1);
        idle(100);
        write(8'h00, 1'b0, 1'b0);   // ignored
        wait_done();
        check("R8", tx_done, 1'b1, "done after captured long frame");
        idle(60);
        check("R7", txd, 1'b1, "no frame from ignored write");
        clear();

        // R2: write in the same cycle as a rollover
        cur_req = "R2";
        tick_per = 1;
        idle(3);
        while (m_cnt != 15) @(negedge clk);
        wr_stb = 1; wr_data = 8'h3C; frame11 = 0;
        @(negedge clk);
        wr_stb = 0;
        check("R2", txd, 1'b1, "rollover in write cycle does not start");
        idle(10);
        check("R2", txd, 1'b1, "still waiting for next rollover");
        wait_done();

        // R7: write in the completion cycle; R6: clear held through completion
        cur_req = "R7";
        clear();
        write(8'h81, 1'b1, 1'b1);
        while (!(m_act && m_q.size() == 0 && m_cnt == 15)) @(negedge clk);
        wr_stb = 1; clr_done = 1; wr_data = 8'h55;
        @(negedge clk);
        wr_stb = 0;
        check("R6", tx_done, 1'b1, "completion wins over clear");
        @(negedge clk);
        clr_done = 0;
        check("R6", tx_done, 1'b0, "held clear takes effect next cycle");
        idle(40);
        check("R7", txd, 1'b1, "write on completion cycle ignored");

        // R9: no ticks, no start
        cur_req = "R9";
        tick_per = 0;
        idle(3);
        write(8'h0F, 1'b0, 1'b0);
        idle(80);
        check("R9", txd, 1'b1, "no start without ticks");
        check("R9", tx_done, 1'b0, "no done without ticks");
        tick_per = 1;
        cur_req = "R3";
        wait_done();
        check("R3", tx_done, 1'b1, "frame completes once ticks resume");
        idle(5);

        finished = 1;
        summary();
    end

endmodule